// File: doc/BRIEF.md
# Preemptible Matrix-Multiply Sequencer

This block is a background engine that forms C = A x B for square integer matrices of a fixed size (10 x 10 by default). The matrices are stored row-major in a word-addressed data memory. Software gives three base addresses and an operation code through a plain configuration strobe. The engine then fetches all of A and then all of B into local tile buffers. It computes every element of C with a triple loop, issuing one multiply-accumulate per cycle in which a shared multiplier is granted to it. Finally it streams C back to memory.

The multiplier belongs to someone else: an external arbiter grants it to the engine only when higher-priority users leave it idle. When the grant is withheld, the engine freezes its loop indices, its partial sum and its operands in place. When the grant returns, it resumes at exactly the same multiply with no replay and no loss of data. Busy, done and a state code are visible as plain status pins.

The memory side uses valid/ready rules. A read request (`rd_valid`, `rd_addr`) and a write (`wr_valid`, `wr_addr`, `wr_data`) stay asserted with a stable payload until the matching ready is high at a clock edge. At most one read is outstanding. Its response (`rd_rsp_valid`, `rd_rsp_data`) may come any number of cycles later, has no ready signal, and is always taken while the engine waits for it. A response is ignored in any other state.

Top module: `mm_seq`

## Requirements
- R1: After reset, busy and done are 0, state_code is 0 (idle), and rd_valid, mul_req and wr_valid are all 0.
- R2: A configuration strobe with cfg_op = 2 while idle latches the three bases. In the next cycle busy is 1, done is 0 and state_code is 2 (read request).
- R3: Exactly 200 reads are accepted. The first 100 go to A base + 0..99 and the next 100 to B base + 0..99, in increasing order. rd_valid and rd_addr hold steady while rd_ready is low.
- R4: After a read is accepted, state_code is 1 (read wait) and stays 1 until rd_rsp_valid is seen. The response latency may be any number of cycles.
- R5: In the compute phase (state_code 3), exactly 1000 granted multiplies are performed. mul_req is high only in that state. With k innermost, then j, then i, the operands are mul_a = A[i*10+k] and mul_b = B[k*10+j].
- R6: While mul_req is high and mul_gnt is low, the state, mul_a and mul_b hold. Execution resumes with the same operand pair when the grant returns.
- R7: C[i*10+j] is the sum over k of A x B, kept as 32-bit two's-complement with wrap-around. The 100 elements are written to C base + 0..99 in increasing order with state_code 4. wr_valid, wr_addr and wr_data hold while wr_ready is low.
- R8: After the last write is accepted, busy is 0, done is 1 and state_code is 0. Done stays 1 until the next accepted start.
- R9: A start strobe while busy is ignored. The running job keeps its state, its bases and its busy flag.
- R10: A configuration strobe with an operation code other than 2 is ignored. The engine stays idle with busy 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_op | input | OPW (4) | Operation code, 2 selects matrix multiply |
| cfg_a_base | input | AW (16) | Word address of A |
| cfg_b_base | input | AW (16) | Word address of B |
| cfg_c_base | input | AW (16) | Word address of C |
| busy | output | 1 | Job in progress |
| done | output | 1 | Last job finished |
| state_code | output | 3 | 0 idle, 1 read wait, 2 read request, 3 compute, 4 write |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW (16) | Read word address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | DW (32) | Read data |
| mul_req | output | 1 | Multiplier requested |
| mul_gnt | input | 1 | Multiplier granted this cycle |
| mul_a | output | DW (32) | Multiplicand |
| mul_b | output | DW (32) | Multiplier operand |
| mul_p | input | DW (32) | Product (low DW bits) of mul_a and mul_b, same cycle |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | AW (16) | Write word address |
| wr_data | output | DW (32) | Write data |

## Verification
The first job runs with the grant, both readies and zero read latency all held high. Any failure there isolates index ordering and accumulation from flow-control effects. The second job uses full-range random values, with a 50% grant rate, random readies, up to three cycles of read latency and a start strobe injected in mid-compute. Together these separate wrap-around arithmetic and back-pressure handling from the ignore-while-busy rule. The third job cuts the grant for a long stretch in the middle of the loop, so a design that drops or repeats a partial sum across preemption gives wrong C values.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_WAIT = 3'd1,
    ST_RD_REQ  = 3'd2,
    ST_MAC     = 3'd3,
    ST_WR      = 3'd4
  } mm_state_e;

  localparam int OP_MATMUL = 2;
endpackage

// File: rtl/mm_tile_buf.sv
module mm_tile_buf #(
  parameter int DEPTH = 100,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/mm_loop_idx.sv
module mm_loop_idx #(
  parameter int DIM = 10,
  localparam int LW = $clog2(DIM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [LW-1:0] row,
  output logic [LW-1:0] col,
  output logic [LW-1:0] dot,
  output logic          dot_last,
  output logic          all_last
);
  localparam logic [LW-1:0] TOP = LW'(DIM - 1);

  assign dot_last = (dot == TOP);
  assign all_last = dot_last && (col == TOP) && (row == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      row <= '0;
      col <= '0;
      dot <= '0;
    end else if (step) begin
      if (dot_last) begin
        dot <= '0;
        if (col == TOP) begin
          col <= '0;
          row <= (row == TOP) ? '0 : row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end else begin
        dot <= dot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mm_seq.sv
module mm_seq #(
  parameter int DIM = 10,
  parameter int DW  = 32,
  parameter int AW  = 16,
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_valid,
  input  logic [OPW-1:0] cfg_op,
  input  logic [AW-1:0]  cfg_a_base,
  input  logic [AW-1:0]  cfg_b_base,
  input  logic [AW-1:0]  cfg_c_base,
  output logic           busy,
  output logic           done,
  output logic [2:0]     state_code,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [AW-1:0]  rd_addr,
  input  logic           rd_rsp_valid,
  input  logic [DW-1:0]  rd_rsp_data,
  output logic           mul_req,
  input  logic           mul_gnt,
  output logic [DW-1:0]  mul_a,
  output logic [DW-1:0]  mul_b,
  input  logic [DW-1:0]  mul_p,
  output logic           wr_valid,
  input  logic           wr_ready,
  output logic [AW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data
);
  import mm_pkg::*;

  localparam int N  = DIM * DIM;
  localparam int IW = $clog2(N);
  localparam int LW = $clog2(DIM);
  localparam logic [IW-1:0] IDX_TOP = IW'(N - 1);

  mm_state_e     state;
  logic          phase_b;
  logic [IW-1:0] idx;
  logic [DW-1:0] acc;
  logic [AW-1:0] base_a, base_b, base_c;

  logic [LW-1:0] li, lj, lk;
  logic          k_last, loop_last;
  logic          mac_fire;
  logic [DW-1:0] a_q, b_q, c_q;
  logic [DW-1:0] sum_next;

  function automatic logic [IW-1:0] flat(input logic [LW-1:0] r, input logic [LW-1:0] c);
    return IW'(r) * IW'(DIM) + IW'(c);
  endfunction

  wire start_hit = cfg_valid && (cfg_op == OPW'(OP_MATMUL));
  wire rsp_take  = (state == ST_RD_WAIT) && rd_rsp_valid;

  assign mac_fire = (state == ST_MAC) && mul_gnt;
  assign sum_next = acc + mul_p;

  // Local tiles: A and B filled from memory, C filled by the loop.
  mm_tile_buf #(.DEPTH(N), .DW(DW)) u_buf_a (
    .clk(clk), .we(rsp_take && !phase_b), .waddr(idx), .wdata(rd_rsp_data),
    .raddr(flat(li, lk)), .rdata(a_q));

  mm_tile_buf #(.DEPTH(N), .DW(DW)) u_buf_b (
    .clk(clk), .we(rsp_take && phase_b), .waddr(idx), .wdata(rd_rsp_data),
    .raddr(flat(lk, lj)), .rdata(b_q));

  mm_tile_buf #(.DEPTH(N), .DW(DW)) u_buf_c (
    .clk(clk), .we(mac_fire && k_last), .waddr(flat(li, lj)), .wdata(sum_next),
    .raddr(idx), .rdata(c_q));

  mm_loop_idx #(.DIM(DIM)) u_loop (
    .clk(clk), .rst_n(rst_n), .clear(state != ST_MAC), .step(mac_fire),
    .row(li), .col(lj), .dot(lk), .dot_last(k_last), .all_last(loop_last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      phase_b <= 1'b0;
      idx     <= '0;
      acc     <= '0;
      base_a  <= '0;
      base_b  <= '0;
      base_c  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_hit) begin
          base_a  <= cfg_a_base;
          base_b  <= cfg_b_base;
          base_c  <= cfg_c_base;
          busy    <= 1'b1;
          done    <= 1'b0;
          phase_b <= 1'b0;
          idx     <= '0;
          state   <= ST_RD_REQ;
        end
        ST_RD_REQ: if (rd_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (rd_rsp_valid) begin
          if (idx == IDX_TOP) begin
            idx <= '0;
            if (phase_b) begin
              acc   <= '0;
              state <= ST_MAC;
            end else begin
              phase_b <= 1'b1;
              state   <= ST_RD_REQ;
            end
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_RD_REQ;
          end
        end
        ST_MAC: if (mul_gnt) begin
          acc <= k_last ? '0 : sum_next;
          if (loop_last) begin
            idx   <= '0;
            state <= ST_WR;
          end
        end
        ST_WR: if (wr_ready) begin
          if (idx == IDX_TOP) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign state_code = state;
  assign rd_valid   = (state == ST_RD_REQ);
  assign rd_addr    = (phase_b ? base_b : base_a) + AW'(idx);
  assign mul_req    = (state == ST_MAC);
  assign mul_a      = a_q;
  assign mul_b      = b_q;
  assign wr_valid   = (state == ST_WR);
  assign wr_addr    = base_c + AW'(idx);
  assign wr_data    = c_q;
endmodule

// File: rtl/mm_seq_chk.sv
module mm_seq_chk #(
  parameter int DW   = 32,
  parameter int AW   = 16,
  parameter int OPW  = 4,
  parameter int MACS = 1000
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_valid,
  input logic [OPW-1:0] cfg_op,
  input logic           busy,
  input logic           done,
  input logic [2:0]     state_code,
  input logic           rd_valid,
  input logic           rd_ready,
  input logic [AW-1:0]  rd_addr,
  input logic           rd_rsp_valid,
  input logic           mul_req,
  input logic           mul_gnt,
  input logic [DW-1:0]  mul_a,
  input logic [DW-1:0]  mul_b,
  input logic           wr_valid,
  input logic           wr_ready,
  input logic [AW-1:0]  wr_addr,
  input logic [DW-1:0]  wr_data
);
  logic [31:0] mac_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || state_code == 3'd0) mac_cnt <= '0;
    else if (mul_req && mul_gnt)      mac_cnt <= mac_cnt + 1;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd0) |-> (!rd_valid && !mul_req && !wr_valid && !busy));

  // R2
  start_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cfg_valid) && $past(cfg_op) == OPW'(2)));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R4
  rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd1 && !rd_rsp_valid) |=> (state_code == 3'd1));

  // R5
  mul_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_req |-> (state_code == 3'd3));

  // R5
  mac_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd4 && $past(state_code) == 3'd3) |-> (mac_cnt == MACS));

  // R6
  preempt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_req && !mul_gnt) |=> (mul_req && $stable(mul_a) && $stable(mul_b)));

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R8
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(cfg_valid));
endmodule

bind mm_seq mm_seq_chk #(.DW(DW), .AW(AW), .OPW(OPW), .MACS(DIM * DIM * DIM)) u_chk (.*);

// File: tb/mm_seq_tb.sv
module mm_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIM = 10;
  localparam int N   = DIM * DIM;
  localparam int RUN_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [3:0]  cfg_op = '0;
  logic [15:0] cfg_a_base = '0, cfg_b_base = '0, cfg_c_base = '0;
  logic        busy, done;
  logic [2:0]  state_code;
  logic        rd_valid, rd_ready = 1'b0;
  logic [15:0] rd_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic        mul_req, mul_gnt = 1'b0;
  logic [31:0] mul_a, mul_b, mul_p = '0;
  logic        wr_valid, wr_ready = 1'b0;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] mem [0:4095];

  always #(CLK_PERIOD / 2) clk = ~clk;

  mm_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_op(cfg_op),
    .cfg_a_base(cfg_a_base), .cfg_b_base(cfg_b_base), .cfg_c_base(cfg_c_base),
    .busy(busy), .done(done), .state_code(state_code),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .mul_req(mul_req), .mul_gnt(mul_gnt), .mul_a(mul_a), .mul_b(mul_b), .mul_p(mul_p),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One complete job against a behavioural memory, multiplier and reference loop.
  task automatic run_job(input int ba, input int bb, input int bc, input int gnt_pct,
                         input int rdy_pct, input int lat_max, input bit poke, input bit outage);
    logic [31:0] expc [N];
    logic [31:0] s;
    int ri = 0, rj = 0, rk = 0, macs = 0, reads = 0, writes = 0, cyc = 0;
    int pend = 0, outage_left = 60;
    logic [15:0] pend_addr = '0;
    bit have_pend = 0, poked = 0, poke_chk = 0, g;
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        s = '0;
        for (int k = 0; k < DIM; k++) s = s + mem[ba + i*DIM + k] * mem[bb + k*DIM + j];
        expc[i*DIM + j] = s;
      end
    cfg_op = 4'd2; cfg_a_base = 16'(ba); cfg_b_base = 16'(bb); cfg_c_base = 16'(bc);
    cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
    chk("R2 busy after start", 32'(busy), 1);
    chk("R2 done cleared", 32'(done), 0);
    chk("R2 state read request", 32'(state_code), 2);
    while (!done && cyc < RUN_LIMIT) begin
      if (poke_chk) begin
        cfg_valid = 1'b0; poke_chk = 0;
        chk("R9 busy kept", 32'(busy), 1);
        chk("R9 state kept", 32'(state_code), 3);
      end
      rd_rsp_valid = 1'b0;
      if (have_pend) begin
        if (pend == 0) begin
          rd_rsp_valid = 1'b1; rd_rsp_data = mem[pend_addr]; have_pend = 0;
        end else pend--;
      end else if (state_code == 3'd1) begin
        chk("R4 waits without response", 32'(rd_valid), 0);
      end
      rd_ready = 1'b0;
      if (rd_valid) begin
        rd_ready = (int'($urandom % 100) < rdy_pct);
        if (rd_ready) begin
          chk("R3 read address", 32'(rd_addr), 32'((reads < N) ? ba + reads : bb + reads - N));
          have_pend = 1; pend = int'($urandom % (lat_max + 1)); pend_addr = rd_addr; reads++;
        end
      end
      mul_gnt = 1'b0; mul_p = '0;
      if (mul_req) begin
        g = (int'($urandom % 100) < gnt_pct);
        if (outage && macs == 500 && outage_left > 0) begin g = 0; outage_left--; end
        if (macs < DIM*DIM*DIM) begin
          chk("R5 operand a", mul_a, mem[ba + ri*DIM + rk]);
          chk("R6 operand b", mul_b, mem[bb + rk*DIM + rj]);
        end else chk("R5 surplus multiply", 32'(macs), DIM*DIM*DIM - 1);
        mul_gnt = g; mul_p = mul_a * mul_b;
        if (g) begin
          macs++;
          if (rk == DIM - 1) begin
            rk = 0;
            if (rj == DIM - 1) begin rj = 0; ri++; end else rj++;
          end else rk++;
        end
        if (poke && !poked && macs == 100) begin
          cfg_a_base = 16'(ba + 1000); cfg_b_base = 16'(bb + 1000); cfg_c_base = 16'(bc + 1000);
          cfg_valid = 1'b1; poked = 1; poke_chk = 1;
        end
      end
      wr_ready = 1'b0;
      if (wr_valid) begin
        wr_ready = (int'($urandom % 100) < rdy_pct);
        if (wr_ready) begin
          chk("R7 write address", 32'(wr_addr), 32'(bc + writes));
          chk("R7 write data", wr_data, (writes < N) ? expc[writes] : 32'hDEAD_BEEF);
          mem[wr_addr] = wr_data; writes++;
        end
      end
      @(negedge clk);
      cyc++;
    end
    rd_ready = 0; rd_rsp_valid = 0; mul_gnt = 0; wr_ready = 0; cfg_valid = 0;
    if (cyc >= RUN_LIMIT) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog R8: actual %0d cycles expected completion", cyc);
    end
    chk("R3 read count", 32'(reads), 2 * N);
    chk("R5 multiply count", 32'(macs), DIM * DIM * DIM);
    chk("R7 write count", 32'(writes), N);
    chk("R8 busy cleared", 32'(busy), 0);
    chk("R8 done set", 32'(done), 1);
    chk("R8 state idle", 32'(state_code), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 state", 32'(state_code), 0);
    chk("R1 requests", 32'({rd_valid, mul_req, wr_valid}), 0);

    cfg_op = 4'd1; cfg_valid = 1'b1;
    @(negedge clk);
    cfg_op = 4'd3;
    @(negedge clk);
    cfg_valid = 1'b0;
    chk("R10 busy", 32'(busy), 0);
    chk("R10 state", 32'(state_code), 0);
    chk("R10 no read", 32'(rd_valid), 0);

    for (int e = 0; e < N; e++) begin
      mem[e]       = 32'(e + 1);
      mem[100 + e] = 32'((e % 7) - 3);
    end
    run_job(0, 100, 200, 100, 100, 0, 0, 0);

    repeat (20) @(negedge clk);
    chk("R8 done sticky", 32'(done), 1);
    chk("R8 busy stays low", 32'(busy), 0);

    for (int e = 0; e < N; e++) begin
      mem[300 + e] = $urandom;
      mem[400 + e] = $urandom;
    end
    run_job(300, 400, 500, 50, 60, 3, 1, 0);

    for (int e = 0; e < N; e++) begin
      mem[600 + e] = 32'(-(e % 13));
      mem[700 + e] = 32'((e * 37) % 101 - 50);
    end
    run_job(600, 700, 800, 80, 100, 1, 0, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule